// File: doc/BRIEF.md
# Programmable-Edge PWM Generator

This block generates one pulse-width-modulated output from a set of static configuration inputs. A two-stage prescaler (a linear divider followed by a power-of-two stretch) sets the length of a time quantum. An up-counter steps once per quantum through one PWM period. The output is active inside a window bounded by a programmable start count and a programmable end count. When the two bounds are equal, the window covers the whole period.

Period and window settings pass through shadow registers. In synchronised mode a new setting takes hold only when the counter wraps. In direct mode it takes hold on the next clock. Two gates control the output. The run gate stops and clears the counters. The output gate forces the idle level but leaves the counter running. An inversion control acts on the next clock. An open-drain option turns the enable output into a pull-low control.

Top module: `pwm_edge_gen`

## Requirements
- R1: One quantum lasts (cfg_div_lin + 1) * 2^cfg_div_shift clock cycles, and the period count advances exactly once per quantum.
- R2: A period spans (cfg_period + 1) quanta: the count runs 0 to cfg_period, then restarts at 0.
- R3: For count c with start S and end E, the output is active when S < E and S <= c < E, and when S > E and (c >= S or c < E).
- R4: When S equals E, the output is active for every count of the period (full duty).
- R5: While cfg_clk_en is 0, the counters are held at zero and the output shows the idle level from the next clock. Settings written meanwhile apply from the first quantum after cfg_clk_en returns to 1, and that quantum is count 0.
- R6: While cfg_pin_en is 0, the output shows the idle level from the next clock, and the period count keeps running underneath.
- R7: pwm_out is the logical output XOR cfg_invert, so the idle level equals cfg_invert. A change of cfg_invert shows on the next clock, without waiting for a period boundary.
- R8: With cfg_open_drain at 1, pwm_oe is 1 exactly when pwm_out is 0. With cfg_open_drain at 0, pwm_oe is 1.
- R9: With cfg_sync_off at 0, a change to the period, start or end applies only from the first quantum of the next period.
- R10: With cfg_sync_off at 1, a change to the start or end applies to the output two clocks after it is driven.
- R11: With cfg_sync_off at 1, shrinking the period below the current count makes the counter restart at 0 on the next quantum tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div_lin | input | DIVL_W | Linear prescaler value; a quantum is this value plus one, before the stretch |
| cfg_div_shift | input | DIVH_W | Power-of-two stretch applied to the quantum |
| cfg_period | input | CNT_W | Last count of a period |
| cfg_rise | input | CNT_W | Count at which the active window opens |
| cfg_fall | input | CNT_W | Count at which the active window closes |
| cfg_clk_en | input | 1 | Run gate; 0 clears the counters and idles the output |
| cfg_pin_en | input | 1 | Output gate; 0 idles the output while the counter runs |
| cfg_invert | input | 1 | Output polarity inversion |
| cfg_open_drain | input | 1 | Selects pull-low-only behaviour for pwm_oe |
| cfg_sync_off | input | 1 | 1 applies new settings at once; 0 defers them to the period boundary |
| pwm_out | output | 1 | Registered PWM level |
| pwm_oe | output | 1 | Output-enable for the pin driver |

## Verification
The bench sweeps quantum lengths, periods and window bounds, including bounds beyond the period, equal bounds and wrapped windows. Each waveform is compared sample by sample against a count derived from the sample index. A design that got the wrap or the equal-bound rule wrong would show a window off by whole quanta, or a flat output where full duty is expected. Directed sequences change the window end and the period in the middle of a period, in both synchronised and direct modes. A design that mis-timed its shadow load would show the new duty one period early or late. A design that ran away after a period shrink would stay low for many samples. Further sequences toggle the output gate and the inversion, and stop and restart the run gate mid-period. These catch a counter that stops when it should keep running, polarity held back to the boundary, and a restart that does not begin at count 0.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;

   // index of each shadowed field in the setting vectors
   localparam int FLD_PERIOD = 0;
   localparam int FLD_RISE   = 1;
   localparam int FLD_FALL   = 2;
   localparam int NUM_FIELDS = 3;

   typedef enum logic [1:0] {
      WIN_ALWAYS,
      WIN_INSIDE,
      WIN_WRAPPED
   } win_kind_e;

   function automatic win_kind_e window_kind(logic same_pts, logic rise_first);
      if (same_pts)        return WIN_ALWAYS;
      else if (rise_first) return WIN_INSIDE;
      else                 return WIN_WRAPPED;
   endfunction

   function automatic logic window_hit(win_kind_e kind, logic past_rise, logic before_fall);
      case (kind)
         WIN_ALWAYS: return 1'b1;
         WIN_INSIDE: return past_rise & before_fall;
         default:    return past_rise | before_fall;
      endcase
   endfunction

endpackage

// File: rtl/pwm_quantum_prescaler.sv
module pwm_quantum_prescaler #(
   parameter int DIVL_W = 8,
   parameter int DIVH_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [DIVL_W-1:0] div_lin,
   input  logic [DIVH_W-1:0] div_shift,
   output logic              tick
);
   localparam int MAX_SH = (1 << DIVH_W) - 1;
   localparam int PRE_W  = DIVL_W + MAX_SH;
   localparam logic [PRE_W:0]   ONE_S = 1;
   localparam logic [PRE_W-1:0] ONE_P = 1;

   if (DIVL_W < 1 || DIVH_W < 1 || DIVH_W > 5) begin : g_bad_widths
      $error("pwm_quantum_prescaler: unsupported divider widths");
   end

   logic [PRE_W:0]   span;
   logic [PRE_W-1:0] limit;
   logic [PRE_W-1:0] cnt;

   always_comb begin
      span  = ({{(PRE_W + 1 - DIVL_W){1'b0}}, div_lin} + ONE_S) << div_shift;
      limit = span[PRE_W-1:0] - ONE_P;
   end

   // >= keeps the count bounded when the divider is lowered on the fly
   assign tick = run && (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || tick)   cnt <= '0;
      else                     cnt <= cnt + ONE_P;
   end

endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] last,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] STEP = 1;

   // >= lets a period shrunk below the count restart on the next tick
   assign wrap = tick && (count >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           count <= '0;
      else if (!run || wrap) count <= '0;
      else if (tick)        count <= count + STEP;
   end

endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs #(
   parameter int CNT_W = 8,
   parameter int NUM   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] next_val [NUM],
   output logic [CNT_W-1:0] held     [NUM]
);
   if (NUM < 1) begin : g_bad_num
      $error("pwm_shadow_regs: NUM must be positive");
   end

   for (genvar g = 0; g < NUM; g++) begin : g_field
      logic [CNT_W-1:0] r_val;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    r_val <= '0;
         else if (load) r_val <= next_val[g];
      end
      assign held[g] = r_val;
   end

endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
   import pwm_edge_pkg::*;
#(
   parameter int DIVL_W = 8,
   parameter int DIVH_W = 4,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIVL_W-1:0] cfg_div_lin,
   input  logic [DIVH_W-1:0] cfg_div_shift,
   input  logic [CNT_W-1:0]  cfg_period,
   input  logic [CNT_W-1:0]  cfg_rise,
   input  logic [CNT_W-1:0]  cfg_fall,
   input  logic              cfg_clk_en,
   input  logic              cfg_pin_en,
   input  logic              cfg_invert,
   input  logic              cfg_open_drain,
   input  logic              cfg_sync_off,
   output logic              pwm_out,
   output logic              pwm_oe
);
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("pwm_edge_gen: CNT_W out of range");
   end

   logic             q_tick;
   logic             q_wrap;
   logic [CNT_W-1:0] q_count;
   logic             shadow_load;
   logic [CNT_W-1:0] cfg_vec [NUM_FIELDS];
   logic [CNT_W-1:0] act_vec [NUM_FIELDS];
   logic [CNT_W-1:0] act_period, act_rise, act_fall;
   win_kind_e        kind;
   logic             in_win;
   logic             logical_lvl;
   logic             next_out;
   logic             out_q, oe_q;

   pwm_quantum_prescaler #(.DIVL_W(DIVL_W), .DIVH_W(DIVH_W)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (cfg_clk_en),
      .div_lin   (cfg_div_lin),
      .div_shift (cfg_div_shift),
      .tick      (q_tick)
   );

   assign cfg_vec[FLD_PERIOD] = cfg_period;
   assign cfg_vec[FLD_RISE]   = cfg_rise;
   assign cfg_vec[FLD_FALL]   = cfg_fall;

   // stopped or direct mode: track settings; synced mode: only at wrap
   assign shadow_load = !cfg_clk_en || cfg_sync_off || q_wrap;

   pwm_shadow_regs #(.CNT_W(CNT_W), .NUM(NUM_FIELDS)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (shadow_load),
      .next_val (cfg_vec),
      .held     (act_vec)
   );

   assign act_period = act_vec[FLD_PERIOD];
   assign act_rise   = act_vec[FLD_RISE];
   assign act_fall   = act_vec[FLD_FALL];

   pwm_period_core #(.CNT_W(CNT_W)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (cfg_clk_en),
      .tick  (q_tick),
      .last  (act_period),
      .count (q_count),
      .wrap  (q_wrap)
   );

   always_comb begin
      kind        = window_kind(act_rise == act_fall, act_rise < act_fall);
      in_win      = window_hit(kind, q_count >= act_rise, q_count < act_fall);
      logical_lvl = cfg_clk_en & cfg_pin_en & in_win;
      next_out    = logical_lvl ^ cfg_invert;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         out_q <= next_out;
         oe_q  <= cfg_open_drain ? ~next_out : 1'b1;
      end
   end

   assign pwm_out = out_q;
   assign pwm_oe  = oe_q;

endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_clk_en,
   input logic             cfg_pin_en,
   input logic             cfg_invert,
   input logic             cfg_open_drain,
   input logic             cfg_sync_off,
   input logic             pwm_out,
   input logic             pwm_oe,
   input logic             tick,
   input logic             wrap,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] act_period,
   input logic [CNT_W-1:0] act_rise,
   input logic [CNT_W-1:0] act_fall
);

   assert_count_needs_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_clk_en && !tick) |=> $stable(count));

   assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (count == '0));

   assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_clk_en && cfg_pin_en && (act_rise == act_fall)) |=> (pwm_out != $past(cfg_invert)));

   assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_clk_en |=> ((count == '0) && (pwm_out == $past(cfg_invert))));

   assert_pin_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_pin_en |=> (pwm_out == $past(cfg_invert)));

   assert_od_pull_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_open_drain |=> (pwm_oe == !pwm_out));

   assert_push_pull_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open_drain |=> pwm_oe);

   assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_clk_en && !cfg_sync_off && !wrap) |=>
         ($stable(act_period) && $stable(act_rise) && $stable(act_fall)));

endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_clk_en     (cfg_clk_en),
   .cfg_pin_en     (cfg_pin_en),
   .cfg_invert     (cfg_invert),
   .cfg_open_drain (cfg_open_drain),
   .cfg_sync_off   (cfg_sync_off),
   .pwm_out        (pwm_out),
   .pwm_oe         (pwm_oe),
   .tick           (q_tick),
   .wrap           (q_wrap),
   .count          (q_count),
   .act_period     (act_period),
   .act_rise       (act_rise),
   .act_fall       (act_fall)
);

// File: tb/pwm_edge_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_edge_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] div_lin = '0;
   logic [3:0] div_shift = '0;
   logic [7:0] period = '0, rise = '0, fall = '0;
   logic       clk_en = 1'b0, pin_en = 1'b0, invert = 1'b0, open_drain = 1'b0, sync_off = 1'b0;
   logic       pwm_out, pwm_oe;

   int n_checks = 0;
   int n_fails  = 0;

   always #2 clk = ~clk;

   pwm_edge_gen dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_div_lin    (div_lin),
      .cfg_div_shift  (div_shift),
      .cfg_period     (period),
      .cfg_rise       (rise),
      .cfg_fall       (fall),
      .cfg_clk_en     (clk_en),
      .cfg_pin_en     (pin_en),
      .cfg_invert     (invert),
      .cfg_open_drain (open_drain),
      .cfg_sync_off   (sync_off),
      .pwm_out        (pwm_out),
      .pwm_oe         (pwm_oe)
   );

   function automatic bit in_window(int c, int s, int e);
      if (s == e)     return 1'b1;
      else if (s < e) return (c >= s) && (c < e);
      else            return (c >= s) || (c < e);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   // take one sample after the next edge and compare the pin level
   task automatic expect_out(bit exp, string req);
      @(negedge clk);
      check(pwm_out == exp, req, int'(pwm_out), int'(exp));
   endtask

   // stop, load settings, restart; next sample is the first after enable
   task automatic start(int l, int h, int p, int r, int f, bit so);
      @(negedge clk);
      clk_en = 1'b0; pin_en = 1'b1; invert = 1'b0; open_drain = 1'b0;
      div_lin = 8'(l); div_shift = 4'(h);
      period = 8'(p); rise = 8'(r); fall = 8'(f); sync_off = so;
      @(negedge clk);
      @(negedge clk);
      clk_en = 1'b1;
   endtask

   task automatic run_cfg(int l, int h, int p, int r, int f, bit so, bit od, bit inv);
      int  q;
      int  bad;
      bit  e_out, e_oe;
      int  a_out, x_out;
      q = (l + 1) << h;
      @(negedge clk);
      clk_en = 1'b0; pin_en = 1'b1; invert = inv; open_drain = od;
      div_lin = 8'(l); div_shift = 4'(h);
      period = 8'(p); rise = 8'(r); fall = 8'(f); sync_off = so;
      @(negedge clk);
      @(negedge clk);
      // R5 R7: stopped output sits at the idle level set by the inversion
      check(pwm_out == inv, "R5 R7 idle level", int'(pwm_out), int'(inv));
      clk_en = 1'b1;
      bad = 0; a_out = 0; x_out = 0;
      for (int i = 0; i < 2 * q * (p + 1); i++) begin
         @(negedge clk);
         e_out = in_window((i / q) % (p + 1), r, f) ^ inv;
         e_oe  = od ? !e_out : 1'b1;
         if ((pwm_out != e_out || pwm_oe != e_oe) && bad == 0) begin
            a_out = {pwm_oe, pwm_out}; x_out = {e_oe, e_out}; bad = 1;
         end
      end
      // R1 R2 R3 R4 R8: whole waveform against the index-derived model
      check(bad == 0, $sformatf("R1 R2 R3 R4 R8 cfg l=%0d h=%0d p=%0d s=%0d e=%0d {oe,out}", l, h, p, r, f),
            a_out, x_out);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog: actual running expected finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(pwm_out == 1'b0, "R5 reset out", int'(pwm_out), 0);
      check(pwm_oe == 1'b1, "R8 reset oe", int'(pwm_oe), 1);

      // sweep of small settings
      for (int l = 0; l < 3; l++)
         for (int h = 0; h < 3; h++)
            for (int p = 0; p < 4; p++)
               for (int r = 0; r < 5; r++)
                  for (int f = 0; f < 5; f++)
                     run_cfg(l, h, p, r, f, r[0], f[0], l == 1);

      // R1: long quanta
      run_cfg(200, 2, 1, 1, 0, 1'b0, 1'b0, 1'b0);
      run_cfg(5, 4, 2, 0, 1, 1'b0, 1'b1, 1'b0);
      run_cfg(0, 0, 255, 0, 255, 1'b0, 1'b0, 1'b0);

      // R9: end moved mid-period, synced
      start(0, 0, 3, 0, 1, 1'b0);
      expect_out(1, "R9 s0");
      fall = 8'd3;
      expect_out(0, "R9 s1"); expect_out(0, "R9 s2"); expect_out(0, "R9 s3");
      expect_out(1, "R9 s4"); expect_out(1, "R9 s5"); expect_out(1, "R9 s6");
      expect_out(0, "R9 s7");

      // R9: period shrunk mid-period, synced
      start(0, 0, 3, 0, 1, 1'b0);
      expect_out(1, "R9 p s0");
      period = 8'd1;
      expect_out(0, "R9 p s1"); expect_out(0, "R9 p s2"); expect_out(0, "R9 p s3");
      expect_out(1, "R9 p s4"); expect_out(0, "R9 p s5"); expect_out(1, "R9 p s6");

      // R10: end moved mid-period, direct
      start(0, 0, 3, 0, 1, 1'b1);
      expect_out(1, "R10 s0");
      fall = 8'd3;
      expect_out(0, "R10 s1"); expect_out(1, "R10 s2"); expect_out(0, "R10 s3");
      expect_out(1, "R10 s4");

      // R11: period shrunk below the count, direct
      start(0, 0, 3, 0, 1, 1'b1);
      expect_out(1, "R11 s0");
      period = 8'd1;
      expect_out(0, "R11 s1"); expect_out(0, "R11 s2"); expect_out(1, "R11 s3");
      expect_out(0, "R11 s4"); expect_out(1, "R11 s5");

      // R6: output gate idles the pin, counter keeps running
      start(0, 0, 3, 0, 2, 1'b0);
      expect_out(1, "R6 s0");
      pin_en = 1'b0;
      expect_out(0, "R6 s1"); expect_out(0, "R6 s2"); expect_out(0, "R6 s3");
      expect_out(0, "R6 s4");
      pin_en = 1'b1;
      expect_out(1, "R6 s5"); expect_out(0, "R6 s6"); expect_out(0, "R6 s7");
      expect_out(1, "R6 s8");

      // R7: inversion applies on the next clock
      start(0, 0, 3, 0, 2, 1'b0);
      expect_out(1, "R7 s0");
      invert = 1'b1;
      expect_out(0, "R7 s1"); expect_out(1, "R7 s2"); expect_out(1, "R7 s3");
      expect_out(0, "R7 s4");
      pin_en = 1'b0;
      expect_out(1, "R7 gated idle");
      pin_en = 1'b1; invert = 1'b0;

      // R5: stop mid-period, change end, restart at count 0
      start(1, 0, 3, 0, 2, 1'b0);
      expect_out(1, "R5 s0"); expect_out(1, "R5 s1"); expect_out(1, "R5 s2");
      clk_en = 1'b0; fall = 8'd1;
      expect_out(0, "R5 stopped");
      clk_en = 1'b1;
      expect_out(1, "R5 r0"); expect_out(1, "R5 r1"); expect_out(0, "R5 r2");
      expect_out(0, "R5 r3");

      summary();
   end

endmodule